// File: doc/BRIEF.md
# Two-Port Mailbox Doorbell Unit

This block gives two agents, called left and right, a small message channel and a doorbell between them. Both agents run on one clock. Each side owns four 16-bit mailboxes. It fills them by word or by single byte and can read them back. It can also read the four mailboxes that the other side owns. Storing into the high byte of a mailbox rings a doorbell toward the other side. The receiving side silences that doorbell by reading the same high byte through its peer-read window. Reading does not change the mailbox contents.

Each side has a control word of its own. The word holds four mask bits. It also holds four cause bits, which record doorbells that arrived while their mask bit was clear. The last field is four status bits, which record every doorbell whether masked or not. The active-low interrupt pin of a side is asserted while any of its cause bits is set. Every access is a single-cycle strobe with a 6-bit register address. The two sides act independently and need no arbitration. Read data comes back from a register one clock after the strobe.

Top module: `mbox_irq_pair`

## Requirements
- R1: A write strobe to address 0x20+n (n = 0..3) stores into the writer's own mailbox n. Bits 15:8 are stored only when the upper-byte enable is high, and bits 7:0 only when the lower-byte enable is high. A read strobe to the same address returns that mailbox. On every read, a byte lane whose enable is low returns zero.
- R2: When the upper-byte enable is high on a mailbox write to 0x20+n, status bit n of the other side is set. A write with only the lower-byte enable high sets no status bit.
- R3: A read strobe to 0x24+n returns mailbox n of the other side. Reading one's own mailboxes at 0x20+n leaves the other side's bits unchanged.
- R4: A read strobe to 0x24+n with the upper-byte enable high clears cause bit n and status bit n of the reader. It leaves the mailbox data unchanged. A read of 0x24+n with only the lower-byte enable high clears nothing.
- R5: The control word sits at address 0x28. A write with the lower-byte enable high loads the mask from bits 3:0 (bit n masks source n, 1 = masked). A write without the lower-byte enable leaves the mask unchanged. The mask reads back in bits 3:0.
- R6: A cause bit is set only by a doorbell that arrives while its mask bit is 0. A masked doorbell sets only the status bit. Clearing the mask afterwards does not raise the cause bit.
- R7: In a control-word read, bits 7:4 return the inverted cause bits and bits 11:8 return the inverted status bits, so 0 means pending. Bits 15:12 read as 0.
- R8: A side's interrupt output is low exactly while at least one of its cause bits is 1. It changes on the same edge as the cause bits.
- R9: If one side rings doorbell n in the same cycle that the other side acknowledges n, the set wins. The status bit stays at 1, and so does the cause bit when the source is unmasked.
- R10: Synchronous reset clears all mailboxes, cause bits and status bits, sets every mask bit to 1, drives both interrupt outputs high and zeroes read data.
- R11: Writes to any address other than 0x20..0x23 and 0x28 change no state. Reads of reserved addresses return 0. In a cycle after an edge with no read strobe, read data is 0.
- R12: Both sides may access the unit in the same cycle, and each access completes exactly as it would alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left access strobe |
| l_wr | input | 1 | Left direction, 1 = write |
| l_ub | input | 1 | Left upper-byte enable (bits 15:8) |
| l_lb | input | 1 | Left lower-byte enable (bits 7:0) |
| l_addr | input | 6 | Left register address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, one cycle after the strobe |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_sel | input | 1 | Right access strobe |
| r_wr | input | 1 | Right direction, 1 = write |
| r_ub | input | 1 | Right upper-byte enable (bits 15:8) |
| r_lb | input | 1 | Right lower-byte enable (bits 7:0) |
| r_addr | input | 6 | Right register address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, one cycle after the strobe |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Every result is due on the first rising edge after the strobe is applied. This covers stored mailbox bytes, status, cause and mask updates, the interrupt pins and the registered read data. The bench drives each strobe on a falling edge and holds it for exactly one cycle. It samples read data and both interrupt pins on the next falling edge, then removes the strobe. Control-word effects are checked by a separate read, whose value arrives one further cycle later. Idle cycles are sampled the same way to confirm that read data has returned to zero.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int unsigned MBX_ADDR_W = 6;
  localparam int unsigned MBX_DATA_W = 16;
  localparam int unsigned MBX_COUNT  = 4;

  // Kind of access a strobe performs, after address decode.
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_OWN_WR,
    ACC_OWN_RD,
    ACC_PEER_RD,
    ACC_CTL_WR,
    ACC_CTL_RD,
    ACC_RSVD
  } acc_kind_e;

endpackage

// File: rtl/mbox_access_dec.sv
module mbox_access_dec
  import mbox_pkg::*;
#(
  parameter int unsigned            ADDR_W   = MBX_ADDR_W,
  parameter int unsigned            NUM_MB   = MBX_COUNT,
  parameter logic [ADDR_W-1:0]      WR_BASE  = 6'h20,
  parameter logic [ADDR_W-1:0]      RD_BASE  = 6'h24,
  parameter logic [ADDR_W-1:0]      CTL_ADDR = 6'h28,
  localparam int unsigned           IDX_W    = $clog2(NUM_MB)
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_MB);

  logic [ADDR_W-1:0] own_off;
  logic [ADDR_W-1:0] peer_off;

  // Unsigned wrap makes one compare cover both range ends.
  assign own_off  = addr - WR_BASE;
  assign peer_off = addr - RD_BASE;

  always_comb begin
    kind = ACC_NONE;
    idx  = '0;
    if (sel) begin
      if (own_off < SPAN) begin
        kind = wr ? ACC_OWN_WR : ACC_OWN_RD;
        idx  = own_off[IDX_W-1:0];
      end else if (peer_off < SPAN) begin
        kind = wr ? ACC_RSVD : ACC_PEER_RD;
        idx  = peer_off[IDX_W-1:0];
      end else if (addr == CTL_ADDR) begin
        kind = wr ? ACC_CTL_WR : ACC_CTL_RD;
      end else begin
        kind = ACC_RSVD;
      end
    end
  end

endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int unsigned  DATA_W = 16,
  parameter int unsigned  NUM_MB = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_MB),
  localparam int unsigned BYTE_W = DATA_W / 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic                           ub,
  input  logic                           lb,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_MB-1:0][DATA_W-1:0]  mb_q
);

  for (genvar n = 0; n < NUM_MB; n++) begin : g_mb
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(n));

    always_ff @(posedge clk) begin
      if (rst) begin
        mb_q[n] <= '0;
      end else if (hit) begin
        if (ub) mb_q[n][DATA_W-1:BYTE_W] <= wdata[DATA_W-1:BYTE_W];
        if (lb) mb_q[n][BYTE_W-1:0]      <= wdata[BYTE_W-1:0];
      end
    end
  end

endmodule

// File: rtl/mbox_irq_bank.sv
module mbox_irq_bank #(
  parameter int unsigned NUM_MB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_MB-1:0] set_vec,
  input  logic [NUM_MB-1:0] clr_vec,
  input  logic              mask_wr,
  input  logic [NUM_MB-1:0] mask_wdata,
  output logic [NUM_MB-1:0] mask_q,
  output logic [NUM_MB-1:0] cause_q,
  output logic [NUM_MB-1:0] status_q,
  output logic              irq_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '1;
      cause_q  <= '0;
      status_q <= '0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      // A doorbell beats an acknowledge of the same source.
      status_q <= set_vec | (status_q & ~clr_vec);
      cause_q  <= (set_vec & ~mask_q) | (cause_q & ~clr_vec);
    end
  end

  assign irq_n = ~|cause_q;

endmodule

// File: rtl/mbox_rdata.sv
module mbox_rdata
  import mbox_pkg::*;
#(
  parameter int unsigned  DATA_W = 16,
  parameter int unsigned  NUM_MB = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_MB),
  localparam int unsigned BYTE_W = DATA_W / 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  acc_kind_e                     kind,
  input  logic [IDX_W-1:0]              idx,
  input  logic                          ub,
  input  logic                          lb,
  input  logic [NUM_MB-1:0][DATA_W-1:0] own_mb,
  input  logic [NUM_MB-1:0][DATA_W-1:0] peer_mb,
  input  logic [NUM_MB-1:0]             mask,
  input  logic [NUM_MB-1:0]             cause,
  input  logic [NUM_MB-1:0]             status,
  output logic [DATA_W-1:0]             rdata_q
);

  logic [DATA_W-1:0] ctl_word;
  logic [DATA_W-1:0] lane;

  always_comb begin
    ctl_word = '0;
    ctl_word[NUM_MB-1:0]          = mask;
    ctl_word[2*NUM_MB-1:NUM_MB]   = ~cause;
    ctl_word[3*NUM_MB-1:2*NUM_MB] = ~status;
  end

  assign lane = {{BYTE_W{ub}}, {BYTE_W{lb}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (kind)
        ACC_OWN_RD:  rdata_q <= own_mb[idx]  & lane;
        ACC_PEER_RD: rdata_q <= peer_mb[idx] & lane;
        ACC_CTL_RD:  rdata_q <= ctl_word     & lane;
        default:     rdata_q <= '0;
      endcase
    end
  end

endmodule

// File: rtl/mbox_irq_pair.sv
module mbox_irq_pair
  import mbox_pkg::*;
#(
  parameter int unsigned       ADDR_W   = MBX_ADDR_W,
  parameter int unsigned       DATA_W   = MBX_DATA_W,
  parameter int unsigned       NUM_MB   = MBX_COUNT,
  parameter logic [ADDR_W-1:0] WR_BASE  = 6'h20,
  parameter logic [ADDR_W-1:0] RD_BASE  = 6'h24,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 6'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_wr,
  input  logic              l_ub,
  input  logic              l_lb,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_sel,
  input  logic              r_wr,
  input  logic              r_ub,
  input  logic              r_lb,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);

  localparam int unsigned SIDES = 2;
  localparam int unsigned IDX_W = $clog2(NUM_MB);

  logic                          p_sel   [SIDES];
  logic                          p_wr    [SIDES];
  logic                          p_ub    [SIDES];
  logic                          p_lb    [SIDES];
  logic [ADDR_W-1:0]             p_addr  [SIDES];
  logic [DATA_W-1:0]             p_wdata [SIDES];
  logic [DATA_W-1:0]             p_rdata [SIDES];
  logic                          p_irq_n [SIDES];

  acc_kind_e                     kind    [SIDES];
  logic [IDX_W-1:0]              idx     [SIDES];
  logic [NUM_MB-1:0]             ring    [SIDES];
  logic [NUM_MB-1:0]             ack     [SIDES];
  logic [NUM_MB-1:0][DATA_W-1:0] mb_q    [SIDES];
  logic [NUM_MB-1:0]             mask_q  [SIDES];
  logic [NUM_MB-1:0]             cause_q [SIDES];
  logic [NUM_MB-1:0]             status_q[SIDES];

  assign p_sel[0]   = l_sel;   assign p_sel[1]   = r_sel;
  assign p_wr[0]    = l_wr;    assign p_wr[1]    = r_wr;
  assign p_ub[0]    = l_ub;    assign p_ub[1]    = r_ub;
  assign p_lb[0]    = l_lb;    assign p_lb[1]    = r_lb;
  assign p_addr[0]  = l_addr;  assign p_addr[1]  = r_addr;
  assign p_wdata[0] = l_wdata; assign p_wdata[1] = r_wdata;

  assign l_rdata = p_rdata[0];
  assign r_rdata = p_rdata[1];
  assign l_irq_n = p_irq_n[0];
  assign r_irq_n = p_irq_n[1];

  for (genvar p = 0; p < SIDES; p++) begin : g_side
    localparam int unsigned Q = SIDES - 1 - p;

    mbox_access_dec #(
      .ADDR_W(ADDR_W), .NUM_MB(NUM_MB),
      .WR_BASE(WR_BASE), .RD_BASE(RD_BASE), .CTL_ADDR(CTL_ADDR)
    ) u_dec (
      .sel  (p_sel[p]),
      .wr   (p_wr[p]),
      .addr (p_addr[p]),
      .kind (kind[p]),
      .idx  (idx[p])
    );

    // Doorbell rung by this side's high-byte store; acknowledge by peer read.
    assign ring[p] = (kind[p] == ACC_OWN_WR && p_ub[p])
                   ? (NUM_MB'(1) << idx[p]) : '0;
    assign ack[p]  = (kind[p] == ACC_PEER_RD && p_ub[p])
                   ? (NUM_MB'(1) << idx[p]) : '0;

    mbox_store #(.DATA_W(DATA_W), .NUM_MB(NUM_MB)) u_store (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (kind[p] == ACC_OWN_WR),
      .wr_idx (idx[p]),
      .ub     (p_ub[p]),
      .lb     (p_lb[p]),
      .wdata  (p_wdata[p]),
      .mb_q   (mb_q[p])
    );

    mbox_irq_bank #(.NUM_MB(NUM_MB)) u_irq (
      .clk        (clk),
      .rst        (rst),
      .set_vec    (ring[Q]),
      .clr_vec    (ack[p]),
      .mask_wr    (kind[p] == ACC_CTL_WR && p_lb[p]),
      .mask_wdata (p_wdata[p][NUM_MB-1:0]),
      .mask_q     (mask_q[p]),
      .cause_q    (cause_q[p]),
      .status_q   (status_q[p]),
      .irq_n      (p_irq_n[p])
    );

    mbox_rdata #(.DATA_W(DATA_W), .NUM_MB(NUM_MB)) u_rd (
      .clk     (clk),
      .rst     (rst),
      .kind    (kind[p]),
      .idx     (idx[p]),
      .ub      (p_ub[p]),
      .lb      (p_lb[p]),
      .own_mb  (mb_q[p]),
      .peer_mb (mb_q[Q]),
      .mask    (mask_q[p]),
      .cause   (cause_q[p]),
      .status  (status_q[p]),
      .rdata_q (p_rdata[p])
    );
  end

endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int unsigned       ADDR_W  = 6,
  parameter int unsigned       DATA_W  = 16,
  parameter int unsigned       NUM_MB  = 4,
  parameter logic [ADDR_W-1:0] WR_BASE = 6'h20,
  parameter logic [ADDR_W-1:0] RD_BASE = 6'h24,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 6'h28,
  localparam int unsigned      IDX_W   = $clog2(NUM_MB)
) (
  input logic              clk,
  input logic              rst,
  input logic              l_sel,
  input logic              l_wr,
  input logic              l_ub,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_irq_n,
  input logic              r_sel,
  input logic              r_wr,
  input logic              r_ub,
  input logic [ADDR_W-1:0] r_addr,
  input logic [NUM_MB-1:0] l_mask,
  input logic [NUM_MB-1:0] l_cause,
  input logic [NUM_MB-1:0] l_status
);

  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_MB);

  logic [ADDR_W-1:0] r_woff;
  logic [ADDR_W-1:0] l_roff;
  logic [ADDR_W-1:0] l_woff;
  logic              r_ring;
  logic              l_ack;
  logic              l_rsvd_rd;

  assign r_woff    = r_addr - WR_BASE;
  assign l_roff    = l_addr - RD_BASE;
  assign l_woff    = l_addr - WR_BASE;
  assign r_ring    = r_sel && r_wr && r_ub && (r_woff < SPAN);
  assign l_ack     = l_sel && !l_wr && l_ub && (l_roff < SPAN);
  assign l_rsvd_rd = l_sel && !l_wr && !(l_woff < SPAN) && !(l_roff < SPAN)
                     && (l_addr != CTL_ADDR);

  // R2: a high-byte store by the right side sets the matching left status bit.
  assert_ring_sets_status_R2: assert property (@(posedge clk) disable iff (rst)
    r_ring |=> l_status[$past(r_woff[IDX_W-1:0])]);

  // R2: a low-byte-only store raises no new status bit.
  assert_low_store_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (r_sel && r_wr && !r_ub && (r_woff < SPAN))
      |=> ((l_status & ~$past(l_status)) == '0));

  // R4: an acknowledge without a competing ring clears cause and status.
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (l_ack && !(r_ring && r_woff == l_roff))
      |=> (!l_status[$past(l_roff[IDX_W-1:0])] && !l_cause[$past(l_roff[IDX_W-1:0])]));

  // R6: a cause bit may only rise where the mask was clear.
  assert_masked_no_cause_R6: assert property (@(posedge clk) disable iff (rst)
    ((l_cause & ~$past(l_cause) & $past(l_mask)) == '0));

  // R5/R6: a pending cause always has its status bit pending too.
  assert_cause_has_status_R6: assert property (@(posedge clk) disable iff (rst)
    ((l_cause & ~l_status) == '0));

  // R9: a ring beats a same-cycle acknowledge of the same source.
  assert_ring_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (l_ack && r_ring && r_woff == l_roff) |=> (l_status[$past(l_roff[IDX_W-1:0])]));

  // R11: reserved reads return zero.
  assert_rsvd_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
    l_rsvd_rd |=> (l_rdata == '0));

  // R10: reset leaves masks set and nothing pending.
  assert_reset_state_R10: assert property (@(posedge clk)
    rst |=> (l_mask == '1 && l_cause == '0 && l_status == '0 && l_irq_n && l_rdata == '0));

endmodule

bind mbox_irq_pair mbox_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_MB(NUM_MB),
  .WR_BASE(WR_BASE), .RD_BASE(RD_BASE), .CTL_ADDR(CTL_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .l_sel    (l_sel),
  .l_wr     (l_wr),
  .l_ub     (l_ub),
  .l_addr   (l_addr),
  .l_rdata  (l_rdata),
  .l_irq_n  (l_irq_n),
  .r_sel    (r_sel),
  .r_wr     (r_wr),
  .r_ub     (r_ub),
  .r_addr   (r_addr),
  .l_mask   (mask_q[0]),
  .l_cause  (cause_q[0]),
  .l_status (status_q[0])
);

// File: tb/tb_mbox_irq_pair.sv
`timescale 1ns/1ps
module tb_mbox_irq_pair;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        l_sel = 0, l_wr = 0, l_ub = 0, l_lb = 0;
  logic [5:0]  l_addr = '0;
  logic [15:0] l_wdata = '0;
  logic [15:0] l_rdata;
  logic        l_irq_n;
  logic        r_sel = 0, r_wr = 0, r_ub = 0, r_lb = 0;
  logic [5:0]  r_addr = '0;
  logic [15:0] r_wdata = '0;
  logic [15:0] r_rdata;
  logic        r_irq_n;

  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 0;
  logic [15:0] l_got, r_got;

  always #2 clk = ~clk;

  mbox_irq_pair dut (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_wr(l_wr), .l_ub(l_ub), .l_lb(l_lb), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_sel(r_sel), .r_wr(r_wr), .r_ub(r_ub), .r_lb(r_lb), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  task automatic chk(input logic ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [15:0] act, input logic [15:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // One strobe cycle on each side, then sample at the following falling edge.
  task automatic step(input logic ls, lw, lu, llb, input logic [5:0] la, input logic [15:0] ld,
                      input logic rs, rw, ru, rlb, input logic [5:0] ra, input logic [15:0] rd);
    @(negedge clk);
    l_sel = ls; l_wr = lw; l_ub = lu; l_lb = llb; l_addr = la; l_wdata = ld;
    r_sel = rs; r_wr = rw; r_ub = ru; r_lb = rlb; r_addr = ra; r_wdata = rd;
    @(negedge clk);
    l_got = l_rdata; r_got = r_rdata;
    l_sel = 0; r_sel = 0;
  endtask

  task automatic lacc(input logic w, u, b, input logic [5:0] a, input logic [15:0] d);
    step(1, w, u, b, a, d, 0, 0, 0, 0, 6'h0, 16'h0);
  endtask

  task automatic racc(input logic w, u, b, input logic [5:0] a, input logic [15:0] d);
    step(0, 0, 0, 0, 6'h0, 16'h0, 1, w, u, b, a, d);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 6'h0, 16'h0, 0, 0, 0, 0, 6'h0, 16'h0);
  endtask

  task automatic t_reset();
    chk_eq("R10 rdata after reset", l_rdata, 16'h0000);
    chk_eq("R10 l_irq_n after reset", {15'h0, l_irq_n}, 16'h0001);
    chk_eq("R10 r_irq_n after reset", {15'h0, r_irq_n}, 16'h0001);
    lacc(0, 1, 1, 6'h28, 0);
    chk_eq("R10 R7 left control word", l_got, 16'h0FFF);
    racc(0, 1, 1, 6'h23, 0);
    chk_eq("R10 right mailbox cleared", r_got, 16'h0000);
  endtask

  task automatic t_byte_writes();
    lacc(1, 0, 1, 6'h21, 16'hAB34);
    racc(0, 1, 1, 6'h28, 0);
    chk_eq("R2 low-only store rings nothing", r_got, 16'h0FFF);
    lacc(0, 1, 1, 6'h21, 0);
    chk_eq("R1 low byte stored alone", l_got, 16'h0034);
    lacc(1, 1, 0, 6'h21, 16'h56CD);
    lacc(0, 1, 1, 6'h21, 0);
    chk_eq("R1 high byte merged", l_got, 16'h5634);
    lacc(0, 0, 1, 6'h21, 0);
    chk_eq("R1 disabled lane reads zero", l_got, 16'h0034);
    racc(0, 1, 1, 6'h28, 0);
    chk_eq("R2 R6 masked ring sets status only", r_got, 16'h0DFF);
    chk_eq("R8 no cause keeps irq high", {15'h0, r_irq_n}, 16'h0001);
  endtask

  task automatic t_peer_and_ack();
    lacc(0, 1, 1, 6'h21, 0);
    racc(0, 1, 1, 6'h28, 0);
    chk_eq("R3 own readback keeps peer status", r_got, 16'h0DFF);
    racc(0, 0, 1, 6'h25, 0);
    chk_eq("R4 low-only peer read data", r_got, 16'h0034);
    racc(0, 1, 1, 6'h28, 0);
    chk_eq("R4 low-only peer read no ack", r_got, 16'h0DFF);
    racc(0, 1, 1, 6'h25, 0);
    chk_eq("R3 peer mailbox read", r_got, 16'h5634);
    racc(0, 1, 1, 6'h28, 0);
    chk_eq("R4 ack clears status", r_got, 16'h0FFF);
    lacc(0, 1, 1, 6'h21, 0);
    chk_eq("R4 ack leaves data", l_got, 16'h5634);
    idle();
    chk_eq("R11 idle rdata left", l_got, 16'h0000);
    chk_eq("R11 idle rdata right", r_got, 16'h0000);
  endtask

  task automatic t_mask_cause();
    racc(1, 0, 1, 6'h28, 16'hFFF0);
    racc(0, 1, 1, 6'h28, 0);
    chk_eq("R5 mask written", r_got, 16'h0FF0);
    racc(1, 1, 0, 6'h28, 16'h00FF);
    racc(0, 1, 1, 6'h28, 0);
    chk_eq("R5 write without low lane ignored", r_got, 16'h0FF0);
    lacc(1, 1, 1, 6'h22, 16'h9911);
    chk_eq("R8 irq low on cause", {15'h0, r_irq_n}, 16'h0000);
    racc(0, 1, 1, 6'h28, 0);
    chk_eq("R6 R7 cause and status pending", r_got, 16'h0BB0);
    racc(0, 1, 0, 6'h26, 0);
    chk_eq("R1 high lane only", r_got, 16'h9900);
    chk_eq("R8 irq released on ack", {15'h0, r_irq_n}, 16'h0001);
    racc(0, 1, 1, 6'h28, 0);
    chk_eq("R4 cause cleared", r_got, 16'h0FF0);
  endtask

  task automatic t_masked_then_unmask();
    racc(1, 0, 1, 6'h28, 16'h0008);
    lacc(1, 1, 0, 6'h23, 16'h7700);
    chk_eq("R6 masked ring no irq", {15'h0, r_irq_n}, 16'h0001);
    racc(0, 1, 1, 6'h28, 0);
    chk_eq("R6 masked ring status only", r_got, 16'h07F8);
    racc(1, 0, 1, 6'h28, 16'h0000);
    racc(0, 1, 1, 6'h28, 0);
    chk_eq("R6 unmask raises no cause", r_got, 16'h07F0);
    chk_eq("R6 irq still high", {15'h0, r_irq_n}, 16'h0001);
    racc(0, 1, 0, 6'h27, 0);
    racc(0, 1, 1, 6'h28, 0);
    chk_eq("R4 masked status acked", r_got, 16'h0FF0);
  endtask

  task automatic t_set_wins();
    lacc(1, 0, 1, 6'h28, 16'h0000);
    racc(1, 1, 0, 6'h20, 16'h1200);
    chk_eq("R8 left irq low", {15'h0, l_irq_n}, 16'h0000);
    step(1, 0, 1, 0, 6'h24, 0, 1, 1, 1, 0, 6'h20, 16'h3400);
    chk_eq("R9 read sees old data", l_got, 16'h1200);
    chk_eq("R9 irq stays low", {15'h0, l_irq_n}, 16'h0000);
    lacc(0, 1, 1, 6'h28, 0);
    chk_eq("R9 ring wins", l_got, 16'h0EE0);
    lacc(0, 1, 0, 6'h24, 0);
    chk_eq("R9 new data", l_got, 16'h3400);
    chk_eq("R4 left irq released", {15'h0, l_irq_n}, 16'h0001);
  endtask

  task automatic t_reserved();
    lacc(1, 1, 1, 6'h00, 16'hFFFF);
    lacc(1, 1, 1, 6'h3F, 16'hFFFF);
    lacc(1, 1, 1, 6'h24, 16'hFFFF);
    lacc(1, 1, 1, 6'h29, 16'hFFFF);
    racc(0, 1, 1, 6'h28, 0);
    chk_eq("R11 reserved writes ring nothing", r_got, 16'h0FF0);
    lacc(0, 1, 1, 6'h28, 0);
    chk_eq("R11 reserved writes keep mask", l_got, 16'h0FF0);
    lacc(0, 1, 1, 6'h20, 0);
    chk_eq("R11 own mailbox untouched", l_got, 16'h0000);
    racc(0, 1, 1, 6'h20, 0);
    chk_eq("R11 peer mailbox untouched", r_got, 16'h3400);
    lacc(0, 1, 1, 6'h10, 0);
    chk_eq("R11 reserved read zero", l_got, 16'h0000);
    lacc(0, 1, 1, 6'h3F, 0);
    chk_eq("R11 top reserved read zero", l_got, 16'h0000);
  endtask

  task automatic t_simultaneous();
    step(1, 1, 1, 1, 6'h22, 16'hA1A2, 1, 1, 1, 1, 6'h21, 16'hB1B2);
    chk_eq("R12 left irq", {15'h0, l_irq_n}, 16'h0000);
    chk_eq("R12 right irq", {15'h0, r_irq_n}, 16'h0000);
    step(1, 0, 1, 1, 6'h25, 0, 1, 0, 1, 1, 6'h26, 0);
    chk_eq("R12 R3 left reads right", l_got, 16'hB1B2);
    chk_eq("R12 R3 right reads left", r_got, 16'hA1A2);
    chk_eq("R12 R4 left acked", {15'h0, l_irq_n}, 16'h0001);
    chk_eq("R12 R4 right acked", {15'h0, r_irq_n}, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte_writes();
    t_peer_and_ack();
    t_mask_cause();
    t_masked_then_unmask();
    t_set_wins();
    t_reserved();
    t_simultaneous();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule